// File: doc/BRIEF.md
# External bus strobe timer

This block runs one programmed transfer on a card-style external bus: a chip select, one of four strobes (I/O read, I/O write, memory output-enable, memory write-enable), an address, and a 16-bit data path. A 32-bit timing word sets every phase of the access in clock cycles. These phases are an optional idle stretch, the setup from chip select to strobe, the strobe width and the hold from strobe to chip-select release. The same word picks the chip select, the strobe kind, the data width and the pins that may stretch the strobe.

Software presents the timing word, a byte address, a byte count and the write data, then pulses `start`. The block raises `busy` and splits the byte count into bus beats of one or two bytes. For each beat it runs the programmed phases, captures read data at the end of the strobe or drives write data, and raises a sticky `done` flag when the last beat finishes. The timing word is captured at start, so it may change while a transfer runs.

Top module: `xbs_strobe_timer`

## Requirements
- R1: While and after a synchronous reset, `busy`, `done`, `bus_dout_en` and `rd_data` are 0, and all of `bus_cs_n` and `bus_strobe_n` are high.
- R2: A start accepted while idle asserts exactly one chip select (`bus_cs_n[k]` low, k = `tim_cfg[29:28]`) on the start edge. The strobe `bus_strobe_n[j]` falls `tim_cfg[3:0]` cycles later, with j = `tim_cfg[31:30]` (0 I/O read, 1 I/O write, 2 output-enable, 3 write-enable). When `tim_cfg[27]` is set, `tim_cfg[22:16]` idle cycles with chip select asserted come before the setup. No other chip select or strobe is ever active.
- R3: The strobe stays low for `tim_cfg[15:8]` cycles, and for one cycle when that field is 0.
- R4: Chip select stays low for `tim_cfg[7:4]` cycles after the strobe rises.
- R5: With `tim_cfg[26]` set, the strobe does not end at an edge where `bus_wait` is high. With the bit clear, `bus_wait` has no effect.
- R6: With `tim_cfg[23]` set and an I/O read selected, the strobe does not end at an edge where `bus_ack` is low. For other strobe kinds, or with the bit clear, `bus_ack` has no effect.
- R7: `tim_cfg[25:24]` picks the beat width: 0 gives 8-bit, 1 gives 16-bit, and 2 or 3 take `bus_wide` at start (1 = 16-bit). A byte count n gives n beats at 8 bits or ceil(n/2) beats at 16 bits. The address starts at `xfer_addr` and steps by 1 or 2 per beat. Chip select is high for exactly one cycle between beats.
- R8: Read strobes (I/O read, output-enable) clear `rd_data` at start and sample `bus_din` on the edge that ends each strobe. A 16-bit beat loads the whole word. An 8-bit beat loads `bus_din[7:0]` into byte 0 on even beats and byte 1 on odd beats.
- R9: Write strobes assert `bus_dout_en` while chip select is low. At 16 bits `bus_dout` is `wr_data`. At 8 bits it is `{8'h00, wr_data[7:0]}` on even beats and `{8'h00, wr_data[15:8]}` on odd beats.
- R10: `busy` is high from the start edge until the edge that ends the last beat. On that edge `done` sets and `busy` clears. `done` holds until `done_clr`, and a set wins over a clear. A byte count that yields zero beats sets `done` on the start edge without any bus activity.
- R11: A start while busy is ignored. Changes of `tim_cfg`, `xfer_addr`, `xfer_len` and `wr_data` after the start edge do not affect the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse |
| done_clr | input | 1 | Clears the done flag |
| tim_cfg | input | 32 | Timing and mode word |
| xfer_addr | input | ADDR_W (24) | First byte address |
| xfer_len | input | LEN_W (8) | Byte count |
| wr_data | input | 16 | Write data word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky completion flag |
| rd_data | output | 16 | Captured read data |
| bus_cs_n | output | 4 | Chip selects, active low |
| bus_strobe_n | output | 4 | Strobes indexed by kind, active low |
| bus_addr | output | ADDR_W (24) | Bus byte address |
| bus_dout | output | 16 | Bus write data |
| bus_dout_en | output | 1 | Bus write data enable |
| bus_din | input | 16 | Bus read data |
| bus_wait | input | 1 | Wait pin, high stretches the strobe |
| bus_ack | input | 1 | Input acknowledge, high lets an I/O read end |
| bus_wide | input | 1 | External 16-bit select |

## Verification
All pins are registered from the next phase, so chip select falls on the start edge itself. The first strobe follows idle plus setup cycles later, and `done` rises exactly idle + setup + strobe + hold cycles per beat, plus one cycle per gap between beats, after start. The bench samples at the falling edge, counting sample 0 as the one just after the start edge. It measures the first strobe index, the active chip-select and strobe counts and the sample where `done` appears, and compares them with those sums. Stall pins are changed only at falling edges, with a known last stalling edge R. The expected strobe length is therefore the larger of the programmed width and R + 1 minus the pre-strobe cycles. Read data is due at the edge that ends the strobe and is checked once `done` is seen.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

  localparam int DATA_W = 16;
  localparam int CNT_W  = 8;

  typedef enum logic [2:0] {
    PH_IDLE, PH_GAP, PH_SETUP, PH_STROBE, PH_HOLD, PH_BREAK
  } phase_e;

  typedef enum logic [1:0] {
    XK_IORD = 2'd0, XK_IOWR = 2'd1, XK_OE = 2'd2, XK_WE = 2'd3
  } xkind_e;

  typedef struct packed {
    xkind_e      kind;
    logic [1:0]  cs;
    logic        gap_en;
    logic        wait_en;
    logic        wide;
    logic        ack_en;
    logic [6:0]  gap;
    logic [7:0]  width;
    logic [3:0]  hold;
    logic [3:0]  setup;
  } cfg_t;

  typedef struct packed {
    phase_e          ph;
    logic [CNT_W-1:0] cnt;
  } step_t;

  function automatic step_t go_strobe(cfg_t c);
    step_t s;
    s.ph  = PH_STROBE;
    s.cnt = (c.width == '0) ? CNT_W'(1) : CNT_W'(c.width);
    return s;
  endfunction

  function automatic step_t go_setup(cfg_t c);
    step_t s;
    if (c.setup != '0) begin
      s.ph  = PH_SETUP;
      s.cnt = CNT_W'(c.setup);
    end else begin
      s = go_strobe(c);
    end
    return s;
  endfunction

  function automatic step_t go_pre(cfg_t c);
    step_t s;
    if (c.gap_en && c.gap != '0) begin
      s.ph  = PH_GAP;
      s.cnt = CNT_W'(c.gap);
    end else begin
      s = go_setup(c);
    end
    return s;
  endfunction

  function automatic step_t go_end(logic last);
    step_t s;
    s.ph  = last ? PH_IDLE : PH_BREAK;
    s.cnt = last ? CNT_W'(0) : CNT_W'(1);
    return s;
  endfunction

  function automatic step_t go_post(cfg_t c, logic last);
    step_t s;
    if (c.hold != '0) begin
      s.ph  = PH_HOLD;
      s.cnt = CNT_W'(c.hold);
    end else begin
      s = go_end(last);
    end
    return s;
  endfunction

  function automatic logic is_read(xkind_e k);
    return (k == XK_IORD) || (k == XK_OE);
  endfunction

endpackage

// File: rtl/xbs_cfg_decode.sv
module xbs_cfg_decode
  import xbs_pkg::*;
(
  input  logic [31:0] tim_cfg,
  input  logic        bus_wide,
  output cfg_t        cfg
);
  logic [1:0] wmode;

  always_comb begin
    wmode       = tim_cfg[25:24];
    cfg.setup   = tim_cfg[3:0];
    cfg.hold    = tim_cfg[7:4];
    cfg.width   = tim_cfg[15:8];
    cfg.gap     = tim_cfg[22:16];
    cfg.ack_en  = tim_cfg[23];
    cfg.wait_en = tim_cfg[26];
    cfg.gap_en  = tim_cfg[27];
    cfg.cs      = tim_cfg[29:28];
    cfg.kind    = xkind_e'(tim_cfg[31:30]);
    case (wmode)
      2'd0:    cfg.wide = 1'b0;
      2'd1:    cfg.wide = 1'b1;
      default: cfg.wide = bus_wide;
    endcase
  end
endmodule

// File: rtl/xbs_phase_seq.sv
module xbs_phase_seq
  import xbs_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] xfer_len,
  input  cfg_t             cfg,
  input  logic             bus_wait,
  input  logic             bus_ack,
  output phase_e           ph,
  output phase_e           ph_nxt,
  output logic             begin_o,
  output logic             adv_o,
  output logic             cap_o,
  output logic             fin_o
);
  localparam int BW = LEN_W + 1;

  step_t         st_q, st_n;
  logic [BW-1:0] left_q, left_n, beats;
  logic          last, stall;

  assign beats = cfg.wide ? BW'(({1'b0, xfer_len} + BW'(1)) >> 1) : {1'b0, xfer_len};
  assign last  = (left_q == BW'(1));
  assign stall = (cfg.wait_en && bus_wait) ||
                 (cfg.ack_en && cfg.kind == XK_IORD && !bus_ack);

  always_comb begin
    st_n    = st_q;
    left_n  = left_q;
    begin_o = 1'b0;
    cap_o   = 1'b0;
    case (st_q.ph)
      PH_IDLE: begin
        if (start) begin
          begin_o = 1'b1;
          left_n  = beats;
          if (beats != '0) st_n = go_pre(cfg);
        end
      end
      PH_GAP: begin
        if (st_q.cnt > CNT_W'(1)) st_n.cnt = st_q.cnt - CNT_W'(1);
        else                      st_n     = go_setup(cfg);
      end
      PH_SETUP: begin
        if (st_q.cnt > CNT_W'(1)) st_n.cnt = st_q.cnt - CNT_W'(1);
        else                      st_n     = go_strobe(cfg);
      end
      PH_STROBE: begin
        if (st_q.cnt > CNT_W'(1)) begin
          st_n.cnt = st_q.cnt - CNT_W'(1);
        end else if (!stall) begin
          cap_o = 1'b1;
          st_n  = go_post(cfg, last);
        end
      end
      PH_HOLD: begin
        if (st_q.cnt > CNT_W'(1)) st_n.cnt = st_q.cnt - CNT_W'(1);
        else                      st_n     = go_end(last);
      end
      PH_BREAK: st_n = go_pre(cfg);
      default:  st_n = go_end(1'b1);
    endcase
    adv_o = (st_n.ph == PH_BREAK) && (st_q.ph != PH_BREAK);
    if (adv_o) left_n = left_q - BW'(1);
    fin_o = ((st_n.ph == PH_IDLE) && (st_q.ph != PH_IDLE)) ||
            (begin_o && beats == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= '{ph: PH_IDLE, cnt: '0};
      left_q <= '0;
    end else begin
      st_q   <= st_n;
      left_q <= left_n;
    end
  end

  assign ph     = st_q.ph;
  assign ph_nxt = st_n.ph;
endmodule

// File: rtl/xbs_datapath.sv
module xbs_datapath
  import xbs_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              begin_i,
  input  logic              adv_i,
  input  logic              cap_i,
  input  cfg_t              cfg,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] bus_din,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic [DATA_W-1:0] rd_data
);
  localparam int HB = DATA_W / 2;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q, dout_q, rd_q;
  logic              lane_q;
  logic [ADDR_W-1:0] step;

  assign step = cfg.wide ? ADDR_W'(2) : ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      wd_q   <= '0;
      dout_q <= '0;
      rd_q   <= '0;
      lane_q <= 1'b0;
    end else if (begin_i) begin
      addr_q <= xfer_addr;
      wd_q   <= wr_data;
      lane_q <= 1'b0;
      rd_q   <= '0;
      dout_q <= cfg.wide ? wr_data : {{HB{1'b0}}, wr_data[HB-1:0]};
    end else begin
      if (adv_i) begin
        addr_q <= addr_q + step;
        lane_q <= ~lane_q;
        if (!cfg.wide)
          dout_q <= {{HB{1'b0}}, lane_q ? wd_q[HB-1:0] : wd_q[DATA_W-1:HB]};
      end
      if (cap_i && is_read(cfg.kind)) begin
        if (cfg.wide)    rd_q <= bus_din;
        else if (lane_q) rd_q <= {bus_din[HB-1:0], rd_q[HB-1:0]};
        else             rd_q <= {rd_q[DATA_W-1:HB], bus_din[HB-1:0]};
      end
    end
  end

  assign bus_addr = addr_q;
  assign bus_dout = dout_q;
  assign rd_data  = rd_q;
endmodule

// File: rtl/xbs_strobe_timer.sv
module xbs_strobe_timer
  import xbs_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              done_clr,
  input  logic [31:0]       tim_cfg,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic [15:0]       wr_data,
  output logic              busy,
  output logic              done,
  output logic [15:0]       rd_data,
  output logic [3:0]        bus_cs_n,
  output logic [3:0]        bus_strobe_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [15:0]       bus_dout,
  output logic              bus_dout_en,
  input  logic [15:0]       bus_din,
  input  logic              bus_wait,
  input  logic              bus_ack,
  input  logic              bus_wide
);
  cfg_t   cfg_live, cfg_q, cfg_sel;
  phase_e ph, ph_nxt;
  logic   begin_p, adv_p, cap_p, fin_p, act_nxt;

  xbs_cfg_decode u_dec (
    .tim_cfg  (tim_cfg),
    .bus_wide (bus_wide),
    .cfg      (cfg_live)
  );

  assign cfg_sel = (ph == PH_IDLE) ? cfg_live : cfg_q;

  xbs_phase_seq #(.LEN_W(LEN_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .xfer_len (xfer_len),
    .cfg      (cfg_sel),
    .bus_wait (bus_wait),
    .bus_ack  (bus_ack),
    .ph       (ph),
    .ph_nxt   (ph_nxt),
    .begin_o  (begin_p),
    .adv_o    (adv_p),
    .cap_o    (cap_p),
    .fin_o    (fin_p)
  );

  xbs_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .begin_i   (begin_p),
    .adv_i     (adv_p),
    .cap_i     (cap_p),
    .cfg       (cfg_sel),
    .xfer_addr (xfer_addr),
    .wr_data   (wr_data),
    .bus_din   (bus_din),
    .bus_addr  (bus_addr),
    .bus_dout  (bus_dout),
    .rd_data   (rd_data)
  );

  assign act_nxt = (ph_nxt == PH_GAP) || (ph_nxt == PH_SETUP) ||
                   (ph_nxt == PH_STROBE) || (ph_nxt == PH_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q        <= '0;
      bus_cs_n     <= 4'hF;
      bus_strobe_n <= 4'hF;
      bus_dout_en  <= 1'b0;
      busy         <= 1'b0;
      done         <= 1'b0;
    end else begin
      if (begin_p) cfg_q <= cfg_live;
      bus_cs_n     <= act_nxt ? ~(4'b0001 << cfg_sel.cs) : 4'hF;
      bus_strobe_n <= (ph_nxt == PH_STROBE) ? ~(4'b0001 << cfg_sel.kind) : 4'hF;
      bus_dout_en  <= act_nxt && !is_read(cfg_sel.kind);
      busy         <= (ph_nxt != PH_IDLE);
      if (fin_p)         done <= 1'b1;
      else if (done_clr) done <= 1'b0;
    end
  end
endmodule

// File: rtl/xbs_checker.sv
module xbs_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              done_clr,
  input logic [3:0]        bus_cs_n,
  input logic [3:0]        bus_strobe_n,
  input logic              bus_dout_en,
  input logic [ADDR_W-1:0] bus_addr
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (bus_cs_n == 4'hF && bus_strobe_n == 4'hF && !busy && !done)); // R1
  AST_ONE_CS: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~bus_cs_n)); // R2
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~bus_strobe_n)); // R2
  AST_STROBE_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe_n != 4'hF) |-> (bus_cs_n != 4'hF)); // R2
  AST_ADDR_MOVES_OFF_CS: assert property (@(posedge clk) disable iff (rst)
    (!$stable(bus_addr) && !$rose(busy)) |-> (bus_cs_n == 4'hF)); // R7
  AST_DOUT_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
    bus_dout_en |-> (bus_cs_n != 4'hF)); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done && !done_clr) |=> done); // R10
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> !busy); // R10
endmodule

bind xbs_strobe_timer xbs_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .busy         (busy),
  .done         (done),
  .done_clr     (done_clr),
  .bus_cs_n     (bus_cs_n),
  .bus_strobe_n (bus_strobe_n),
  .bus_dout_en  (bus_dout_en),
  .bus_addr     (bus_addr)
);

// File: tb/tb_xbs_strobe_timer.sv
module tb_xbs_strobe_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, done_clr = 1'b0;
  logic [31:0] tim_cfg = '0;
  logic [23:0] xfer_addr = '0;
  logic [7:0]  xfer_len = '0;
  logic [15:0] wr_data = '0;
  logic        busy, done, bus_dout_en;
  logic [15:0] rd_data, bus_dout;
  logic [15:0] bus_din = '0;
  logic [3:0]  bus_cs_n, bus_strobe_n;
  logic [23:0] bus_addr;
  logic        bus_wait = 1'b0, bus_ack = 1'b1, bus_wide = 1'b0;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  xbs_strobe_timer dut (
    .clk(clk), .rst(rst), .start(start), .done_clr(done_clr),
    .tim_cfg(tim_cfg), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
    .wr_data(wr_data), .busy(busy), .done(done), .rd_data(rd_data),
    .bus_cs_n(bus_cs_n), .bus_strobe_n(bus_strobe_n), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din),
    .bus_wait(bus_wait), .bus_ack(bus_ack), .bus_wide(bus_wide)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(int setup, int hold, int width, int gap,
      bit gap_en, bit ack_en, int wmode, bit wait_en, int cs, int kind);
    logic [31:0] c;
    c = '0;
    c[3:0]   = 4'(setup);
    c[7:4]   = 4'(hold);
    c[15:8]  = 8'(width);
    c[22:16] = 7'(gap);
    c[23]    = ack_en;
    c[25:24] = 2'(wmode);
    c[26]    = wait_en;
    c[27]    = gap_en;
    c[29:28] = 2'(cs);
    c[31:30] = 2'(kind);
    return c;
  endfunction

  function automatic logic [15:0] din_of(logic [23:0] a);
    return {a[7:0] ^ 8'hC3, a[7:0] + 8'h11};
  endfunction

  // One transfer; stall_r = last edge index at which wait is high and ack low
  task automatic run_xfer(input logic [31:0] c, input logic [23:0] a, input logic [7:0] len,
      input logic [15:0] wd, input bit wpin, input int stall_r, input bit poke);
    int k, cs_cnt, stb_cnt, s_first, stray, busy_bad, nb, T;
    int setup, hold, wp, pre, sl0, beats, kind, csel, exp_t;
    bit wide, rd_kind, stall_on, prev_stb;
    logic [23:0] addr_obs[8];
    logic [15:0] dout_obs[8], exp_rd, exp_do;
    bit den_obs[8];
    setup = int'(c[3:0]); hold = int'(c[7:4]);
    wp    = (c[15:8] == 0) ? 1 : int'(c[15:8]);
    pre   = (c[27] ? int'(c[22:16]) : 0) + setup;
    kind  = int'(c[31:30]); csel = int'(c[29:28]);
    wide  = (c[25:24] == 2'd1) || (c[25:24] >= 2'd2 && wpin);
    rd_kind = (kind == 0) || (kind == 2);
    beats = wide ? (int'(len) + 1) / 2 : int'(len);
    stall_on = c[26] || (c[23] && kind == 0);
    sl0 = wp;
    if (stall_on && (stall_r + 1 - pre) > wp) sl0 = stall_r + 1 - pre;
    exp_t = (beats == 0) ? 0 : beats * (pre + hold) + sl0 + (beats - 1) * wp + (beats - 1);

    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
    check(done == 1'b0, "R10 done cleared", done, 0);
    tim_cfg = c; xfer_addr = a; xfer_len = len; wr_data = wd; bus_wide = wpin;
    bus_wait = (stall_r > 0); bus_ack = !(stall_r > 0); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0; cs_cnt = 0; stb_cnt = 0; s_first = -1; stray = 0; busy_bad = 0; nb = 0;
    prev_stb = 1'b0;
    while (!done && k < 4000) begin
      if (bus_cs_n != 4'hF) begin
        cs_cnt++;
        if (bus_cs_n != ~(4'b0001 << csel)) stray++;
      end
      if (bus_strobe_n != 4'hF) begin
        stb_cnt++;
        if (s_first < 0) s_first = k;
        if (bus_strobe_n != ~(4'b0001 << kind)) stray++;
        if (!prev_stb && nb < 8) begin
          addr_obs[nb] = bus_addr; dout_obs[nb] = bus_dout; den_obs[nb] = bus_dout_en;
          nb++;
        end
      end
      prev_stb = (bus_strobe_n != 4'hF);
      if (!busy) busy_bad++;
      bus_din  = din_of(bus_addr);
      bus_wait = (k < stall_r);
      bus_ack  = !(k < stall_r);
      start    = poke && (k == 1);
      if (poke && k == 1) begin
        xfer_addr = ~a; tim_cfg = ~c; xfer_len = 8'd7; wr_data = ~wd;
      end
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    T = k;
    check(T == exp_t, "R10 cycles to done", T, exp_t);
    check(busy_bad == 0, "R10 busy during transfer", busy_bad, 0);
    check(busy == 1'b0, "R10 busy clear at done", busy, 0);
    check(stray == 0, "R2 only selected cs/strobe", stray, 0);
    check(cs_cnt == ((beats == 0) ? 0 : exp_t - (beats - 1)), "R4 cs active cycles",
          cs_cnt, (beats == 0) ? 0 : exp_t - (beats - 1));
    check(stb_cnt == ((beats == 0) ? 0 : sl0 + (beats - 1) * wp), "R3 strobe cycles",
          stb_cnt, (beats == 0) ? 0 : sl0 + (beats - 1) * wp);
    check(nb == ((beats > 8) ? 8 : beats), "R7 beat count", nb, beats);
    if (beats > 0) check(s_first == pre, "R2 setup to strobe", s_first, pre);
    exp_rd = '0;
    for (int b = 0; b < beats; b++) begin
      logic [23:0] ea;
      ea = a + 24'(wide ? 2 * b : b);
      if (rd_kind) begin
        if (wide) exp_rd = din_of(ea);
        else if (b % 2 == 1) exp_rd[15:8] = din_of(ea) & 16'h00FF;
        else exp_rd[7:0] = din_of(ea) & 16'h00FF;
      end
      exp_do = wide ? wd : ((b % 2 == 1) ? {8'h00, wd[15:8]} : {8'h00, wd[7:0]});
      if (b < nb) begin
        check(addr_obs[b] == ea, "R7 beat address", addr_obs[b], ea);
        check(den_obs[b] == !rd_kind, "R9 dout enable", den_obs[b], !rd_kind);
        if (!rd_kind) check(dout_obs[b] == exp_do, "R9 write data lane", dout_obs[b], exp_do);
      end
    end
    check(rd_data == exp_rd, "R8 read data", rd_data, exp_rd);
  endtask

  initial begin
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check(bus_cs_n == 4'hF && bus_strobe_n == 4'hF, "R1 reset pins", {bus_cs_n, bus_strobe_n}, 8'hFF);
    check(!busy && !done && !bus_dout_en && rd_data == 0, "R1 reset status",
          {busy, done, bus_dout_en}, 0);
    rst = 1'b0;
    @(negedge clk);

    // directed corners
    run_xfer(mk_cfg(2, 3, 4, 0, 0, 0, 1, 0, 1, 2), 24'h000100, 8'd2, 16'hA55A, 0, 0, 0); // R2 R3 R4 wide OE
    run_xfer(mk_cfg(0, 0, 0, 0, 0, 0, 1, 0, 0, 0), 24'h000040, 8'd2, 16'h0, 0, 0, 0);   // R3 zero width
    run_xfer(mk_cfg(1, 1, 2, 5, 1, 0, 1, 0, 3, 3), 24'h000200, 8'd2, 16'h1234, 0, 0, 0); // R2 idle insert
    run_xfer(mk_cfg(1, 1, 2, 5, 0, 0, 1, 0, 2, 3), 24'h000200, 8'd2, 16'h1234, 0, 0, 0); // R2 idle off
    run_xfer(mk_cfg(2, 1, 3, 0, 0, 0, 1, 1, 0, 2), 24'h000300, 8'd2, 16'h0, 0, 12, 0);   // R5 stretch
    run_xfer(mk_cfg(2, 1, 3, 0, 0, 0, 1, 0, 0, 2), 24'h000300, 8'd2, 16'h0, 0, 12, 0);   // R5 ignored
    run_xfer(mk_cfg(1, 2, 2, 0, 0, 1, 1, 0, 1, 0), 24'h000310, 8'd2, 16'h0, 0, 9, 0);    // R6 ack IORD
    run_xfer(mk_cfg(1, 2, 2, 0, 0, 1, 1, 0, 1, 2), 24'h000310, 8'd2, 16'h0, 0, 9, 0);    // R6 ack on OE ignored
    run_xfer(mk_cfg(1, 2, 2, 0, 0, 0, 1, 0, 1, 0), 24'h000310, 8'd2, 16'h0, 0, 9, 0);    // R6 ack bit clear
    run_xfer(mk_cfg(1, 1, 2, 0, 0, 0, 0, 0, 2, 0), 24'h000401, 8'd2, 16'h0, 0, 0, 0);    // R7 R8 narrow read
    run_xfer(mk_cfg(1, 1, 2, 0, 0, 0, 1, 0, 2, 2), 24'h000500, 8'd5, 16'h0, 0, 0, 0);    // R7 wide odd count
    run_xfer(mk_cfg(0, 2, 1, 0, 0, 0, 0, 0, 3, 1), 24'h000600, 8'd3, 16'hBEEF, 0, 0, 0); // R9 narrow write
    run_xfer(mk_cfg(1, 0, 1, 0, 0, 0, 2, 0, 0, 3), 24'h000700, 8'd4, 16'hCAFE, 1, 0, 0); // R7 pin wide
    run_xfer(mk_cfg(1, 0, 1, 0, 0, 0, 3, 0, 0, 3), 24'h000700, 8'd4, 16'hCAFE, 0, 0, 0); // R7 pin narrow
    run_xfer(mk_cfg(3, 3, 3, 0, 0, 0, 1, 0, 1, 1), 24'h000800, 8'd0, 16'h1111, 0, 0, 0); // R10 zero length
    run_xfer(mk_cfg(2, 2, 6, 0, 0, 0, 1, 0, 2, 2), 24'h000900, 8'd2, 16'h0, 0, 0, 1);    // R11 start while busy

    // R10 sticky done and clear
    repeat (4) @(negedge clk);
    check(done == 1'b1, "R10 done sticky", done, 1);
    done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
    check(done == 1'b0, "R10 done_clr", done, 0);

    // constrained random transfers
    for (int i = 0; i < 40; i++) begin
      run_xfer(mk_cfg($urandom % 16, $urandom % 16, $urandom % 21, $urandom % 11,
                      1'($urandom % 2), 1'b0, $urandom % 4, 1'b0, $urandom % 4, $urandom % 4),
               24'($urandom), 8'($urandom % 7), 16'($urandom), 1'($urandom % 2), 0, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule